// File: doc/BRIEF.md
# Pipelined Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands with a chain of shift-and-add stages. Each stage looks at two bits of operand B. For each of those bits it gates operand A with an AND and adds the result into a running partial sum, which it then registers. A new operand pair can therefore enter on every clock. Operand A and the bits of B that have not been used yet move through the pipeline with the partial sum. The two product bits that each stage completes are passed through a staircase of delay registers, so that the whole result appears together at the end.

The caller raises `in_vld` together with the operands. The product leaves with `out_vld` after a fixed latency. There is no stall and no backpressure. A parameter selects the output: the full product, only the upper A_W bits, or only the lower B_W bits. In the low-half mode every stage keeps only the accumulator bits that can still reach the lower half, so the adders become narrower the further they sit in the chain. The asynchronous active-low reset is released in step with the clock. It clears only the valid pipeline.

Top module: `mulpipe_top`

## Requirements
- R1: In full mode (MODE = OUT_FULL) `prod` equals op_a * op_b as an unsigned number of A_W+B_W bits.
- R2: The result and `out_vld` appear after the eighth rising edge, counting the edge that samples `in_vld` (B_W/2 stages). `out_vld` is never high when no accepted operand is in flight.
- R3: The block accepts one operand pair on every clock with no bubbles. Back-to-back inputs give back-to-back results, and no more than B_W/2 items are ever in flight.
- R4: The sequence of `out_vld` is the sequence of accepted `in_vld`, delayed by the latency, gaps included.
- R5: While reset is low `out_vld` is 0. Asserting reset in the middle of a run discards every item in flight. After reset is released, `out_vld` stays 0 until new valid input has travelled through.
- R6: If either operand is zero, the product is zero.
- R7: The largest operands are handled without losing a carry: 0xFFFF * 0xFFFF gives 0xFFFE0001.
- R8: In high mode (MODE = OUT_HIGH) `prod` is A_W bits wide and equals bits [A_W+B_W-1:B_W] of the full product.
- R9: In low mode (MODE = OUT_LOW) `prod` is B_W bits wide and equals bits [B_W-1:0] of the full product.
- R10: When both B bits that a stage examines are 0, that stage adds nothing to the partial sum, and the two bits it completes equal the low two bits of the partial sum it received.
- R11: Operand values presented while `in_vld` is low are ignored. They produce no `out_vld`, and they do not change any later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_vld | input | 1 | Operands on op_a/op_b are valid this cycle |
| op_a | input | A_W | Multiplicand, unsigned |
| op_b | input | B_W | Multiplier, unsigned, B_W even |
| out_vld | output | 1 | `prod` holds a finished result |
| prod | output | A_W+B_W, A_W or B_W by MODE | Product, full, upper part or lower part |

## Verification
The bench builds three copies with the default 16-by-16 operands, one for each output mode, and drives all three from the same stimulus. The full copy checks the untrimmed datapath with the widest carries. The high copy shows that the upper bits stand on their own without the staircase. The low copy runs with adders that narrow from stage to stage, which exposes any truncation that drops a bit still needed in the lower half. Random valid gaps, sparse B patterns with zero bit pairs, and a reset in the middle of a run test the alignment of the delay staircase against the valid pipeline.

// File: rtl/mulpipe_pkg.sv
package mulpipe_pkg;

  typedef enum logic [1:0] {
    OUT_FULL = 2'd0,
    OUT_HIGH = 2'd1,
    OUT_LOW  = 2'd2
  } out_mode_e;

  // Width of the product port for a given output selection.
  function automatic int out_w(out_mode_e m, int aw, int bw);
    case (m)
      OUT_FULL: return aw + bw;
      OUT_HIGH: return aw;
      default:  return bw;
    endcase
  endfunction

  // Width of the right-aligned partial sum entering stage k.
  // The low mode keeps only the bits that can still reach the low half.
  function automatic int acc_w(out_mode_e m, int aw, int bw, int k);
    int r;
    if (m != OUT_LOW) return aw;
    r = bw - 2 * k;
    if (r > aw) r = aw;
    if (r < 1)  r = 1;
    return r;
  endfunction

endpackage

// File: rtl/mulpipe_stage.sv
module mulpipe_stage #(
  parameter int A_W      = 16,
  parameter int B_IN_W   = 16,
  parameter int ACC_IN_W = 16,
  parameter int ACC_OUT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 vld_i,
  input  logic [A_W-1:0]       a_i,
  input  logic [B_IN_W-1:0]    b_i,
  input  logic [ACC_IN_W-1:0]  acc_i,
  output logic                 vld_o,
  output logic [A_W-1:0]       a_o,
  output logic [((B_IN_W > 2) ? B_IN_W - 2 : 1)-1:0] b_o,
  output logic [ACC_OUT_W-1:0] acc_o,
  output logic [1:0]           lo_o
);

  localparam int SUM_W = ACC_OUT_W + 2;
  localparam int B_OUT_W = (B_IN_W > 2) ? B_IN_W - 2 : 1;

  logic [SUM_W-1:0] acc_ext;
  logic [SUM_W-1:0] pp_even;
  logic [SUM_W-1:0] pp_odd;
  logic [SUM_W-1:0] sum_d;

  logic             vld_q, vld_d;
  logic [A_W-1:0]   a_q, a_d;
  logic [ACC_OUT_W-1:0] acc_q, acc_d;
  logic [1:0]       lo_q, lo_d;

  // Two AND-gated partial products folded into one adder input each.
  always_comb begin
    acc_ext = SUM_W'(acc_i);
    pp_even = SUM_W'(a_i) & {SUM_W{b_i[0]}};
    pp_odd  = SUM_W'({a_i, 1'b0}) & {SUM_W{b_i[1]}};
    sum_d   = acc_ext + pp_even + pp_odd;
  end

  // Next-state with the valid strobe as clock enable.
  always_comb begin
    vld_d = vld_i;
    a_d   = a_q;
    acc_d = acc_q;
    lo_d  = lo_q;
    if (vld_i) begin
      a_d   = a_i;
      acc_d = sum_d[SUM_W-1:2];
      lo_d  = sum_d[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    a_q   <= a_d;
    acc_q <= acc_d;
    lo_q  <= lo_d;
  end

  // Unused B bits travel on, two fewer per stage.
  generate
    if (B_IN_W > 2) begin : g_bfwd
      logic [B_OUT_W-1:0] b_q, b_d;
      always_comb begin
        b_d = b_q;
        if (vld_i) b_d = b_i[B_IN_W-1:2];
      end
      always_ff @(posedge clk) b_q <= b_d;
      assign b_o = b_q;
    end else begin : g_bend
      assign b_o = '0;
    end
  endgenerate

  assign vld_o = vld_q;
  assign a_o   = a_q;
  assign acc_o = acc_q;
  assign lo_o  = lo_q;

  AST_IDLE_PAIR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && b_i[1:0] == 2'b00) |=> (lo_o == $past(acc_ext[1:0]))) // R10
    else $error("stage with zero B pair altered the completed bits");

endmodule

// File: rtl/mulpipe_lsb_stair.sv
module mulpipe_lsb_stair #(
  parameter int STAGES = 8
) (
  input  logic                    clk,
  input  logic [STAGES-1:0]       vld_i,
  input  logic [STAGES-1:0][1:0]  lo_i,
  output logic [2*STAGES-1:0]     lo_o
);

  // Step j holds 2*(j+1) completed bits, aligned with the output of stage j+1.
  generate
    for (genvar j = 0; j < STAGES - 1; j++) begin : g_st
      logic [2*(j+1)-1:0] bun;
      logic [2*(j+1)-1:0] q, d;
      if (j == 0) begin : g_first
        assign bun = lo_i[0];
      end else begin : g_next
        assign bun = {lo_i[j], g_st[j-1].q};
      end
      always_comb begin
        d = q;
        if (vld_i[j]) d = bun;
      end
      always_ff @(posedge clk) q <= d;
    end
  endgenerate

  assign lo_o = {lo_i[STAGES-1], g_st[STAGES-2].q};

endmodule

// File: rtl/mulpipe_top.sv
module mulpipe_top #(
  parameter int A_W = 16,
  parameter int B_W = 16,
  parameter mulpipe_pkg::out_mode_e MODE = mulpipe_pkg::OUT_FULL
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [A_W-1:0] op_a,
  input  logic [B_W-1:0] op_b,
  output logic           out_vld,
  output logic [mulpipe_pkg::out_w(MODE, A_W, B_W)-1:0] prod
);

  import mulpipe_pkg::*;

  localparam int STAGES = B_W / 2;
  localparam int P_W    = out_w(MODE, A_W, B_W);
  localparam int LAST_W = acc_w(MODE, A_W, B_W, STAGES);
  localparam int CNT_W  = $clog2(STAGES + 2);

  // Reset: asserted at once, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic [STAGES-1:0]      vld_all;
  logic [STAGES-1:0][1:0] lo_all;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      localparam int BI_W  = B_W - 2 * k;
      localparam int BO_W  = (BI_W > 2) ? BI_W - 2 : 1;
      localparam int ACI_W = acc_w(MODE, A_W, B_W, k);
      localparam int ACO_W = acc_w(MODE, A_W, B_W, k + 1);

      logic             vld_in;
      logic [A_W-1:0]   a_in;
      logic [BI_W-1:0]  b_in;
      logic [ACI_W-1:0] acc_in;
      logic             vld;
      logic [A_W-1:0]   a;
      logic [BO_W-1:0]  b;
      logic [ACO_W-1:0] acc;
      logic [1:0]       lo;

      if (k == 0) begin : g_head
        assign vld_in = in_vld;
        assign a_in   = op_a;
        assign b_in   = op_b;
        assign acc_in = '0;
      end else begin : g_link
        assign vld_in = g_stage[k-1].vld;
        assign a_in   = g_stage[k-1].a;
        assign b_in   = g_stage[k-1].b;
        assign acc_in = g_stage[k-1].acc;
      end

      mulpipe_stage #(
        .A_W      (A_W),
        .B_IN_W   (BI_W),
        .ACC_IN_W (ACI_W),
        .ACC_OUT_W(ACO_W)
      ) stage_i (
        .clk  (clk),
        .rst_n(rst_sync_n),
        .vld_i(vld_in),
        .a_i  (a_in),
        .b_i  (b_in),
        .acc_i(acc_in),
        .vld_o(vld),
        .a_o  (a),
        .b_o  (b),
        .acc_o(acc),
        .lo_o (lo)
      );

      assign vld_all[k] = vld;
      assign lo_all[k]  = lo;
    end
  endgenerate

  logic [LAST_W-1:0] acc_last;
  assign acc_last = g_stage[STAGES-1].acc;

  generate
    if (MODE == OUT_HIGH) begin : g_out_high
      assign prod = P_W'(acc_last);
    end else begin : g_out_low_bits
      logic [B_W-1:0] low_bits;
      mulpipe_lsb_stair #(.STAGES(STAGES)) stair_i (
        .clk  (clk),
        .vld_i(vld_all),
        .lo_i (lo_all),
        .lo_o (low_bits)
      );
      if (MODE == OUT_FULL) begin : g_full
        assign prod = {acc_last, low_bits};
      end else begin : g_low
        assign prod = low_bits;
      end
    end
  endgenerate

  assign out_vld = vld_all[STAGES-1];

  // In-flight bookkeeping and zero-operand tags that feed the assertions.
  logic [CNT_W-1:0]  infl_q, infl_d;
  logic [STAGES-1:0] zero_q, zero_d;

  always_comb begin
    infl_d = infl_q + CNT_W'(in_vld) - CNT_W'(out_vld);
    zero_d = {zero_q[STAGES-2:0], in_vld && (op_a == '0 || op_b == '0)};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      infl_q <= '0;
      zero_q <= '0;
    end else begin
      infl_q <= infl_d;
      zero_q <= zero_d;
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_sync_n |-> !out_vld) // R5
    else $error("result valid during reset");

  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    infl_q <= CNT_W'(STAGES)) // R3
    else $error("more items in flight than stages");

  AST_NO_PHANTOM_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (infl_q == '0) |-> !out_vld) // R2
    else $error("valid with nothing in flight");

  AST_ZERO_PRODUCT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_vld && zero_q[STAGES-1]) |-> (prod == '0)) // R6
    else $error("zero operand gave nonzero product");

endmodule

// File: tb/mulpipe_top_tb_top.sv
module mulpipe_top_tb_top;
  import mulpipe_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int A_W = 16;
  localparam int B_W = 16;
  localparam int LAT = 8;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic           rst_n;
  logic           in_vld;
  logic [A_W-1:0] op_a;
  logic [B_W-1:0] op_b;
  logic           vld_f, vld_h, vld_l;
  logic [A_W+B_W-1:0] prod_f;
  logic [A_W-1:0]     prod_h;
  logic [B_W-1:0]     prod_l;

  mulpipe_top #(.A_W(A_W), .B_W(B_W), .MODE(OUT_FULL)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .out_vld(vld_f), .prod(prod_f));
  mulpipe_top #(.A_W(A_W), .B_W(B_W), .MODE(OUT_HIGH)) dut_hi_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .out_vld(vld_h), .prod(prod_h));
  mulpipe_top #(.A_W(A_W), .B_W(B_W), .MODE(OUT_LOW)) dut_lo_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
    .out_vld(vld_l), .prod(prod_l));

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int cyc = 0;
  bit                 hv [16];
  logic [A_W+B_W-1:0] hp [16];
  string              ht [16];

  function automatic logic [A_W+B_W-1:0] ref_mul(logic [A_W-1:0] a, logic [B_W-1:0] b);
    return (A_W+B_W)'(a) * (A_W+B_W)'(b);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // One cycle: compare what leaves now, then drive what enters at the next edge.
  task automatic step(input bit v, input logic [A_W-1:0] a, input logic [B_W-1:0] b,
                      input string tag);
    int old;
    @(negedge clk);
    old = (cyc + 16 - LAT) % 16;
    chk({"R2 R4 full valid ", ht[old]}, 32'(vld_f), 32'(hv[old]));
    chk({"R4 high valid ", ht[old]}, 32'(vld_h), 32'(hv[old]));
    chk({"R4 low valid ", ht[old]}, 32'(vld_l), 32'(hv[old]));
    if (hv[old]) begin
      chk({"R1 full ", ht[old]}, prod_f, hp[old]);
      chk({"R8 high ", ht[old]}, 32'(prod_h), 32'(hp[old][A_W+B_W-1:B_W]));
      chk({"R9 low ", ht[old]}, 32'(prod_l), 32'(hp[old][B_W-1:0]));
    end
    in_vld = v;
    op_a = a;
    op_b = b;
    hv[cyc % 16] = v;
    hp[cyc % 16] = ref_mul(a, b);
    ht[cyc % 16] = tag;
    cyc++;
  endtask

  function automatic logic [15:0] pick16();
    int r;
    r = $urandom % 8;
    if (r == 0) return 16'h0000;
    if (r == 1) return 16'hFFFF;
    return 16'($urandom);
  endfunction

  task automatic flush(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 16'($urandom), 16'($urandom), tag);
  endtask

  initial begin
    void'($urandom(32'h1234_5EED));
    rst_n = 1'b0;
    in_vld = 1'b0;
    op_a = '0;
    op_b = '0;
    for (int i = 0; i < 16; i++) begin hv[i] = 1'b0; hp[i] = '0; ht[i] = "idle"; end

    // R5: outputs idle under reset, then after release
    for (int i = 0; i < 4; i++) step(1'b0, '0, '0, "R5 reset");
    rst_n = 1'b1;
    flush(4, "R5 release");

    // Directed corners, back to back (R3, R6, R7)
    step(1'b1, 16'h0000, 16'h1234, "R6 a zero");
    step(1'b1, 16'h4321, 16'h0000, "R6 b zero");
    step(1'b1, 16'hFFFF, 16'hFFFF, "R7 max");
    step(1'b1, 16'h0001, 16'hFFFF, "R3 one");
    step(1'b1, 16'h8000, 16'h8000, "R3 msb");
    step(1'b1, 16'hAAAA, 16'h5555, "R3 alt");
    step(1'b1, 16'hFFFF, 16'h0001, "R3 unit");
    step(1'b1, 16'h00FF, 16'hFF00, "R3 split");
    flush(LAT + 2, "R3 drain");

    // Random with gaps; invalid slots carry junk operands (R4, R11)
    for (int i = 0; i < 1500; i++)
      step(($urandom % 4) != 0, pick16(), pick16(), "R11 random gaps");
    flush(LAT, "R11 drain");

    // Sparse B with whole bit pairs zero (R10)
    for (int i = 0; i < 600; i++) begin
      logic [15:0] m;
      m = '0;
      for (int p = 0; p < 8; p++) if ($urandom % 3 == 0) m[2*p +: 2] = 2'b11;
      step(1'b1, pick16(), 16'($urandom) & m, "R10 sparse b");
    end

    // Reset in mid-stream discards everything in flight (R5)
    for (int i = 0; i < 5; i++) step(1'b1, pick16(), pick16(), "R5 before reset");
    rst_n = 1'b0;
    for (int i = 0; i < 16; i++) hv[i] = 1'b0;
    #1;
    chk("R5 async clear", 32'(vld_f | vld_h | vld_l), 32'd0);
    flush(3, "R5 held");
    rst_n = 1'b1;
    flush(LAT + 3, "R5 after");

    // Continuous full-rate random (R1, R3)
    for (int i = 0; i < 800; i++) step(1'b1, pick16(), pick16(), "R1 full rate");
    flush(LAT + 2, "R1 drain");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule